// File: doc/BRIEF.md
# AES Round Linear Layer

This block applies the linear half of one AES round to a 128-bit state that has already been through byte substitution. One pass rotates the rows (left for encryption, right for decryption), multiplies every column by the forward or inverse mixing matrix over GF(2^8), and XORs the result with the round key. A last-round flag skips the column mix, so the same unit serves both the middle rounds and the final round of either direction.

A round controller drives the substituted state, the matching round key, the direction and the last-round flag together with a valid strobe. The result appears on the output register one clock later, with a registered valid bit. When no valid input is offered, the output register keeps its contents. S-box logic, key expansion and round counting belong to the surrounding cipher.

Top module: `aes_lin_round`

## Requirements
- R1: State byte k (0 to 15) sits at bits [127-8k -: 8] of a state bus, and is row k mod 4 of column k div 4; byte 0 is the most significant byte.
- R2: With `in_dir`=0 (encrypt), row r of output column c is taken from input column (c+r) mod 4, so row r rotates left by r bytes.
- R3: With `in_dir`=1 (decrypt), row r of output column c is taken from input column (c-r) mod 4, so row r rotates right by r bytes.
- R4: With `in_dir`=0 and `in_last`=0, each shifted column is multiplied by the circulant matrix whose first row is 02 03 01 01, with bytes reduced by x^8+x^4+x^3+x+1 (a left shift that overflows XORs in 0x1B).
- R5: With `in_dir`=1 and `in_last`=0, each shifted column is multiplied by the circulant matrix whose first row is 0e 0b 0d 09.
- R6: The 128-bit round key is XORed bitwise onto the state after the shift and the mix.
- R7: With `in_last`=1 the column mix is skipped in both directions; the output is the shifted state XOR the key.
- R8: `out_valid` equals `in_valid` of the previous clock, and `out_state` carries the result of the input presented one clock earlier.
- R9: While `in_valid`=0, `out_state` keeps its value whatever the state, key, direction and flag inputs do.
- R10: While `rst_n`=0, `out_valid` is 0 and `out_state` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input state, key and controls are valid this cycle |
| in_dir | input | 1 | 0 = encryption transforms, 1 = decryption transforms |
| in_last | input | 1 | 1 = final round, column mix skipped |
| in_state | input | 128 | State after byte substitution |
| in_key | input | 128 | Round key |
| out_valid | output | 1 | Registered valid, one clock after `in_valid` |
| out_state | output | 128 | Registered next state |

## Verification
The only internal state is the output register and its valid bit, so a wrong value shows up at the ports in the very next cycle after the input that caused it; nothing is hidden across several rounds. A wrong row offset or rotation sense moves whole bytes between columns, a fault in the xtime reduction corrupts only bytes whose top bits were set, and a mix that is not skipped on the last round changes every column. A register that loads while valid is low shows as an output that changes on an idle cycle, and is caught by comparing against a behavioural model on every clock.

// File: rtl/aes_lin_pkg.sv
package aes_lin_pkg;

    localparam int ROWS = 4;
    localparam logic [7:0] REDUCE_LOW = 8'h1B;

    typedef logic [7:0] gf_byte_t;

    // multiply by 02 in GF(2^8)
    function automatic gf_byte_t gf_dbl(input gf_byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? REDUCE_LOW : 8'h00);
    endfunction

endpackage

// File: rtl/aes_lin_shift.sv
module aes_lin_shift
    import aes_lin_pkg::*;
#(
    parameter int COLS = 4,
    localparam int W = ROWS * COLS * 8
) (
    input  logic [W-1:0] state_i,
    input  logic         inv_i,
    output logic [W-1:0] state_o
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int DST = c * ROWS + r;
            localparam int SRC_L = ((c + r) % COLS) * ROWS + r;
            localparam int SRC_R = ((c + COLS - (r % COLS)) % COLS) * ROWS + r;
            assign state_o[W-1-8*DST -: 8] = inv_i ? state_i[W-1-8*SRC_R -: 8]
                                                   : state_i[W-1-8*SRC_L -: 8];
        end
    end

endmodule

// File: rtl/aes_lin_mixcol.sv
module aes_lin_mixcol
    import aes_lin_pkg::*;
(
    input  logic [31:0] col_i,
    input  logic        inv_i,
    output logic [31:0] col_o
);

    gf_byte_t m1 [ROWS];
    gf_byte_t m2 [ROWS];
    gf_byte_t m4 [ROWS];
    gf_byte_t m8 [ROWS];

    // shared doubling chain: x1, x2, x4, x8 per byte
    for (genvar i = 0; i < ROWS; i++) begin : g_chain
        assign m1[i] = col_i[31-8*i -: 8];
        assign m2[i] = gf_dbl(m1[i]);
        assign m4[i] = gf_dbl(m2[i]);
        assign m8[i] = gf_dbl(m4[i]);
    end

    for (genvar i = 0; i < ROWS; i++) begin : g_out
        localparam int J1 = (i + 1) % ROWS;
        localparam int J2 = (i + 2) % ROWS;
        localparam int J3 = (i + 3) % ROWS;
        gf_byte_t fwd_b;
        gf_byte_t inv_b;
        // 02*a0 ^ 03*a1 ^ a2 ^ a3
        assign fwd_b = m2[i] ^ m2[J1] ^ m1[J1] ^ m1[J2] ^ m1[J3];
        // 0e*a0 ^ 0b*a1 ^ 0d*a2 ^ 09*a3
        assign inv_b = (m8[i]  ^ m4[i]  ^ m2[i])
                     ^ (m8[J1] ^ m2[J1] ^ m1[J1])
                     ^ (m8[J2] ^ m4[J2] ^ m1[J2])
                     ^ (m8[J3] ^ m1[J3]);
        assign col_o[31-8*i -: 8] = inv_i ? inv_b : fwd_b;
    end

endmodule

// File: rtl/aes_lin_round.sv
module aes_lin_round
    import aes_lin_pkg::*;
#(
    parameter int COLS = 4,
    localparam int W = ROWS * COLS * 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_dir,
    input  logic         in_last,
    input  logic [W-1:0] in_state,
    input  logic [W-1:0] in_key,
    output logic         out_valid,
    output logic [W-1:0] out_state
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] st;
    } pipe_t;

    pipe_t        pipe_d;
    pipe_t        pipe_q;
    logic [W-1:0] shifted;
    logic [W-1:0] mixed;

    aes_lin_shift #(.COLS(COLS)) u_shift (
        .state_i (in_state),
        .inv_i   (in_dir),
        .state_o (shifted)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_mix
        aes_lin_mixcol u_mix (
            .col_i (shifted[W-1-32*c -: 32]),
            .inv_i (in_dir),
            .col_o (mixed[W-1-32*c -: 32])
        );
    end

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = in_valid;
        if (in_valid) begin
            pipe_d.st = (in_last ? shifted : mixed) ^ in_key;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.vld;
    assign out_state = pipe_q.st;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                        // R8
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                      // R8
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_state));                              // R9
    AST_LAST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_state == ($past(shifted) ^ $past(in_key))); // R7

endmodule

// File: tb/aes_lin_round_bench.sv
`timescale 1ns/1ps
module aes_lin_round_bench;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_dir;
    logic         in_last;
    logic [127:0] in_state;
    logic [127:0] in_key;
    logic         out_valid;
    logic [127:0] out_state;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    aes_lin_round u_aes_lin_round (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dir    (in_dir),
        .in_last   (in_last),
        .in_state  (in_state),
        .in_key    (in_key),
        .out_valid (out_valid),
        .out_state (out_state)
    );

    // generic shift-and-add multiply in GF(2^8)
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k,
                                               input logic dir, input logic last);
        logic [7:0] a [4][4];
        logic [7:0] t [4][4];
        logic [7:0] coef [4];
        logic [127:0] res;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                a[r][c] = s[127 - 8*(4*c + r) -: 8];
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                t[r][c] = dir ? a[r][(c + 4 - r) % 4] : a[r][(c + r) % 4];
        if (!last) begin
            if (dir) begin coef[0]=8'h0e; coef[1]=8'h0b; coef[2]=8'h0d; coef[3]=8'h09; end
            else     begin coef[0]=8'h02; coef[1]=8'h03; coef[2]=8'h01; coef[3]=8'h01; end
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 4; i++) begin
                    logic [7:0] v = 8'h00;
                    for (int j = 0; j < 4; j++) v = v ^ gmul(coef[(j + 4 - i) % 4], t[j][c]);
                    a[i][c] = v;
                end
        end else begin
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++) a[r][c] = t[r][c];
        end
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                res[127 - 8*(4*c + r) -: 8] = a[r][c];
        return res ^ k;
    endfunction

    // cycle model
    logic         exp_v;
    logic [127:0] exp_st;
    string        exp_tag;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            exp_v   <= 1'b0;
            exp_st  <= '0;
            exp_tag <= "R10";
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_st  <= ref_round(in_state, in_key, in_dir, in_last);
                exp_tag <= in_last ? (in_dir ? "R3/R7" : "R2/R7")
                                   : (in_dir ? "R5/R6" : "R4/R6");
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            n_cmp++;
            if (out_valid !== exp_v) begin
                n_bad++;
                $display("FAIL R8 cycle %0d: out_valid %b expected %b", cyc, out_valid, exp_v);
            end else if (out_state !== exp_st) begin
                n_bad++;
                $display("FAIL %s cycle %0d: out_state %h expected %h", exp_tag, cyc, out_state, exp_st);
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic d, input logic l,
                         input logic [127:0] s, input logic [127:0] k);
        in_valid = v; in_dir = d; in_last = l; in_state = s; in_key = k;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    localparam logic [127:0] KEY_A  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] COL_IN = {4{32'hdb135345}};
    localparam logic [127:0] COL_MX = {4{32'h8e4da1bc}};
    localparam logic [127:0] SEQ    = 128'h000102030405060708090a0b0c0d0e0f;

    initial begin
        logic [127:0] held;
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        chk("R10", {127'd0, out_valid}, 128'd0);
        chk("R10", out_state, 128'd0);
        rst_n = 1'b1;

        drive(1'b1, 1'b0, 1'b0, COL_IN, '0);
        @(negedge clk);
        chk("R4", out_state, COL_MX);
        chk("R8", {127'd0, out_valid}, 128'd1);

        drive(1'b1, 1'b1, 1'b0, COL_MX, '0);
        @(negedge clk);
        chk("R5", out_state, COL_IN);

        drive(1'b1, 1'b0, 1'b1, SEQ, '0);
        @(negedge clk);
        chk("R2 R1", out_state, 128'h00050a0f04090e03080d02070c01060b);

        drive(1'b1, 1'b1, 1'b1, SEQ, '0);
        @(negedge clk);
        chk("R3 R1", out_state, 128'h000d0a0704010e0b0805020f0c090603);

        drive(1'b1, 1'b0, 1'b0, COL_IN, KEY_A);
        @(negedge clk);
        chk("R6", out_state, COL_MX ^ KEY_A);

        drive(1'b1, 1'b1, 1'b1, COL_MX, KEY_A);
        @(negedge clk);
        chk("R7", out_state, COL_MX ^ KEY_A);

        drive(1'b1, 1'b0, 1'b1, COL_IN, KEY_A);
        @(negedge clk);
        chk("R7", out_state, COL_IN ^ KEY_A);

        held = out_state;
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, i[0], ~i[0], {4{$urandom}}, {4{$urandom}});
            @(negedge clk);
            chk("R9", out_state, held);
            chk("R8", {127'd0, out_valid}, 128'd0);
        end

        for (int i = 0; i < 400; i++) begin
            logic [3:0] m = 4'($urandom);
            drive(m[0] | m[3], m[1], m[2] & m[3], {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom});
            @(negedge clk);
        end

        drive(1'b0, 1'b0, 1'b0, '0, '0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule